// File: doc/BRIEF.md
# Parallel Disk Register-Access Sequencer

This block is the host-side engine for single register accesses on a 40-pin parallel disk port in programmed-I/O mode. The host side offers a request and accepts it only when the engine is idle. A request gives the direction, the register bank, a 3-bit register offset and the write data. The engine then runs one complete bus cycle. It drives the register address and the matching active-low bank select, waits out an address setup interval and pulses the active-low read or write strobe for a minimum width. It then holds the address through a recovery interval and releases everything. A one-cycle done pulse ends the access, and for reads it returns the sampled data.

Every interval is a count of clock cycles. Each count is rounded up from a nanosecond figure at the configured clock period. The setup count also carries a programmable number of extra cycles, because some drives need the address held stable well past the nominal setup time. A drive that is slow to respond can hold its ready line low to extend the strobe. The transfer width comes from the address alone. Offset 0 of the primary bank is the only 16-bit register, and every other register moves on the low byte lane. Offsets 0 to 5 of the secondary bank are not implemented, so a request to one of them finishes without any bus activity.

Top module: `pio_seq`

## Requirements
- R1: After reset both bank selects and both strobes are high (inactive), the data output enable and `rsp_done` are low, and `req_ready` is high.
- R2: A strobe goes low only after the bank select and address have been valid for exactly SETUP cycles, where SETUP = ceil(SETUP_NS/CLK_NS) + EXTRA_SETUP (5 at default parameters).
- R3: With `bus_rdy` high, a strobe stays low for exactly STROBE = ceil(STROBE_NS/CLK_NS) cycles (8 at default).
- R4: When USE_READY is 1, a low `bus_rdy` at the end of the minimum strobe width keeps the strobe low, one cycle at a time, until `bus_rdy` is sampled high.
- R5: After the strobe rises, the bank select and address stay valid for HOLD = ceil(RECOV_NS/CLK_NS) cycles (3 at default) and then both selects go high. `rsp_done` is high for exactly one cycle, the cycle after the last hold cycle, so it arrives SETUP+STROBE+waits+HOLD+1 cycles after the accepting edge.
- R6: Bank 0 (primary) asserts `bus_cs0_n` low and bank 1 (secondary) asserts `bus_cs1_n` low. `bus_addr` equals the request offset throughout the access.
- R7: Primary offset 0 moves 16 bits. All other registers move 8 bits: `bus_dout[15:8]` is zero on writes, and `rsp_rdata[15:8]` is returned as zero on reads whatever the drive puts on D15..D8.
- R8: Read data is the value on `bus_din` in the last cycle of the strobe. It is presented on `rsp_rdata` with `rsp_done` and kept unchanged by later writes.
- R9: `bus_doe` is high only during writes, from the first setup cycle through the first cycle after the write strobe rises. The write data is stable across the rising edge of the write strobe.
- R10: A request to secondary offsets 0 to 5 causes no bank select and no strobe. `rsp_done` pulses in the cycle after acceptance with `rsp_rdata` equal to zero.
- R11: `req_ready` is high only when the engine is idle and not signalling done. A request raised while busy is ignored and starts no later access.
- R12: Both strobes are never low together, both bank selects are never low together, and everything is inactive between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | 0 = primary bank, 1 = secondary bank |
| req_addr | input | 3 | Register offset within the bank |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data of the last read |
| bus_cs0_n | output | 1 | Primary bank select, active low |
| bus_cs1_n | output | 1 | Secondary bank select, active low |
| bus_addr | output | 3 | Register address lines |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Data driven onto the bus |
| bus_doe | output | 1 | Tri-state enable for bus_dout |
| bus_din | input | 16 | Data read from the bus |
| bus_rdy | input | 1 | Drive ready; low stretches the strobe |

## Verification
A phase counter that loads the wrong value shows up at the pins as a setup, strobe or hold interval of the wrong length. The bench measures each interval per access, so the error is reported at the done pulse of the first access it affects. A state machine that leaves a phase early or late moves the done pulse away from its computed cycle. Reads sampled in the wrong cycle return a decoy value, because the modelled drive puts its true data on the bus only in the final strobe cycle. An enable or lane mask tied to the wrong condition is exposed by the captured write data, the enable observed at the write strobe's rising edge, or the upper byte of a narrow read.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

    localparam int unsigned DW = 16;
    localparam int unsigned AW = 3;
    localparam int unsigned HW = DW / 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef enum logic {
        BANK_PRI = 1'b0,
        BANK_SEC = 1'b1
    } bank_e;

    typedef struct packed {
        logic          write;
        bank_e         bank;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } req_t;

    // Round a nanosecond minimum up to whole cycles, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Only offset 0 of the primary bank is a full-width register.
    function automatic logic reg_is_wide(bank_e b, logic [AW-1:0] a);
        return (b == BANK_PRI) && (a == '0);
    endfunction

    // The secondary bank implements its two top offsets only.
    function automatic logic reg_is_valid(bank_e b, logic [AW-1:0] a);
        return (b == BANK_PRI) || (a >= AW'(6));
    endfunction

    function automatic logic [DW-1:0] fit_lane(logic wide, logic [DW-1:0] d);
        return wide ? d : {{(DW-HW){1'b0}}, d[HW-1:0]};
    endfunction

endpackage

// File: rtl/pio_decode.sv
`timescale 1ns/1ps
module pio_decode
    import pio_pkg::*;
(
    input  req_t          rq,
    output logic          valid,
    output logic          wide,
    output logic [DW-1:0] wdata_fit
);
    always_comb begin
        valid     = reg_is_valid(rq.bank, rq.addr);
        wide      = reg_is_wide(rq.bank, rq.addr);
        wdata_fit = fit_lane(wide, rq.wdata);
    end
endmodule

// File: rtl/pio_timer.sv
`timescale 1ns/1ps
module pio_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TIMER_LOAD_SEEN: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)))
        else $error("timer did not take load value"); // R2
endmodule

// File: rtl/pio_seq.sv
`timescale 1ns/1ps
module pio_seq
    import pio_pkg::*;
#(
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned SETUP_NS    = 25,
    parameter int unsigned STROBE_NS   = 80,
    parameter int unsigned RECOV_NS    = 30,
    parameter int unsigned EXTRA_SETUP = 2,
    parameter bit          USE_READY   = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_bank,
    input  logic [2:0]    req_addr,
    input  logic [15:0]   req_wdata,
    output logic          rsp_done,
    output logic [15:0]   rsp_rdata,
    output logic          bus_cs0_n,
    output logic          bus_cs1_n,
    output logic [2:0]    bus_addr,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic [15:0]   bus_dout,
    output logic          bus_doe,
    input  logic [15:0]   bus_din,
    input  logic          bus_rdy
);
    localparam int unsigned SETUP_CYC  = ns_to_cyc(SETUP_NS, CLK_NS) + EXTRA_SETUP;
    localparam int unsigned STROBE_CYC = ns_to_cyc(STROBE_NS, CLK_NS);
    localparam int unsigned HOLD_CYC   = ns_to_cyc(RECOV_NS, CLK_NS);
    localparam int unsigned MAX_CYC    = max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
    localparam int unsigned CW         = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    phase_e        state;
    req_t          cur;
    logic          cur_wide;
    logic          hold_first;
    logic          done_q;
    logic [DW-1:0] rdata_q;

    req_t          in_req;
    logic          in_valid;
    logic          in_wide;
    logic [DW-1:0] in_wfit;
    logic          accept;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_exp;
    logic          drive_rdy;

    assign in_req = '{write: req_write, bank: bank_e'(req_bank),
                      addr: req_addr, wdata: req_wdata};

    pio_decode u_dec (
        .rq        (in_req),
        .valid     (in_valid),
        .wide      (in_wide),
        .wdata_fit (in_wfit)
    );

    pio_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    assign drive_rdy = bus_rdy || !USE_READY;
    assign req_ready = (state == PH_IDLE) && !done_q;
    assign accept    = req_valid && req_ready;

    // Phase counter reload at each phase boundary.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            PH_IDLE:   if (accept && in_valid) begin
                           t_load = 1'b1; t_val = CW'(SETUP_CYC - 1);
                       end
            PH_SETUP:  if (t_exp) begin
                           t_load = 1'b1; t_val = CW'(STROBE_CYC - 1);
                       end
            PH_STROBE: if (t_exp && drive_rdy) begin
                           t_load = 1'b1; t_val = CW'(HOLD_CYC - 1);
                       end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PH_IDLE;
            cur        <= '0;
            cur_wide   <= 1'b0;
            hold_first <= 1'b0;
            done_q     <= 1'b0;
            rdata_q    <= '0;
        end else begin
            done_q     <= 1'b0;
            hold_first <= 1'b0;
            unique case (state)
                PH_IDLE: if (accept) begin
                    cur       <= in_req;
                    cur.wdata <= in_wfit;
                    cur_wide  <= in_wide;
                    if (in_valid) begin
                        state <= PH_SETUP;
                    end else begin
                        done_q  <= 1'b1;
                        rdata_q <= '0;
                    end
                end
                PH_SETUP: if (t_exp) state <= PH_STROBE;
                PH_STROBE: if (t_exp && drive_rdy) begin
                    if (!cur.write) rdata_q <= fit_lane(cur_wide, bus_din);
                    state      <= PH_HOLD;
                    hold_first <= 1'b1;
                end
                PH_HOLD: if (t_exp) begin
                    state  <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    logic active;
    assign active    = (state != PH_IDLE);
    assign bus_cs0_n = !(active && cur.bank == BANK_PRI);
    assign bus_cs1_n = !(active && cur.bank == BANK_SEC);
    assign bus_addr  = active ? cur.addr : '0;
    assign bus_rd_n  = !(state == PH_STROBE && !cur.write);
    assign bus_wr_n  = !(state == PH_STROBE &&  cur.write);
    assign bus_dout  = cur.wdata;
    assign bus_doe   = cur.write && (state == PH_SETUP || state == PH_STROBE ||
                                     (state == PH_HOLD && hold_first));
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;

    // ---------------- checks on the pin behaviour ----------------
    localparam logic [15:0] SU_MIN = 16'(SETUP_CYC);
    localparam logic [15:0] ST_MIN = 16'(STROBE_CYC);

    logic        cs_on, st_on;
    logic [15:0] su_len, st_len;
    assign cs_on = !bus_cs0_n || !bus_cs1_n;
    assign st_on = !bus_rd_n  || !bus_wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            su_len <= '0;
            st_len <= '0;
        end else begin
            if (!cs_on)                          su_len <= '0;
            else if (!st_on && su_len != '1)     su_len <= su_len + 1'b1;
            if (!st_on)                          st_len <= '0;
            else if (st_len != '1)               st_len <= st_len + 1'b1;
        end
    end

    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(st_on) |-> (su_len >= SU_MIN))
        else $error("strobe before setup elapsed"); // R2
    AST_STROBE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(st_on) |-> (st_len >= ST_MIN))
        else $error("strobe too short"); // R3
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n))
        else $error("both strobes low"); // R12
    AST_NO_DUAL_SELECT: assert property (@(posedge clk) disable iff (rst)
        !(!bus_cs0_n && !bus_cs1_n))
        else $error("both selects low"); // R12
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == PH_IDLE) |-> (!cs_on && !st_on && !bus_doe))
        else $error("bus active while idle"); // R12
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cs_on && $past(cs_on)) |-> $stable(bus_addr))
        else $error("address moved during access"); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done)
        else $error("done longer than one cycle"); // R5
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_doe)
        else $error("data driven during read"); // R9
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> (bus_doe && $stable(bus_dout)))
        else $error("write data not held past strobe"); // R9
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !cs_on)
        else $error("ready while busy"); // R11
endmodule

// File: tb/pio_seq_tb.sv
`timescale 1ns/1ps
module pio_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S_CYC = (25 + 10 - 1) / 10 + 2;
    localparam int W_CYC = (80 + 10 - 1) / 10;
    localparam int H_CYC = (30 + 10 - 1) / 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
    logic [2:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic bus_cs0_n, bus_cs1_n, bus_rd_n, bus_wr_n, bus_doe;
    logic [2:0] bus_addr;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = 16'h0;
    logic bus_rdy = 1'b1;

    pio_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n), .bus_addr(bus_addr),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy(bus_rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [15:0] mem [2][8];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic bit exp_valid(bit b, logic [2:0] a);
        return (b == 1'b0) || (a == 3'd6) || (a == 3'd7);
    endfunction
    function automatic logic [15:0] exp_fit(bit b, logic [2:0] a, logic [15:0] d);
        return (b == 1'b0 && a == 3'd0) ? d : {8'h00, d[7:0]};
    endfunction

    // transaction context and bus monitor
    bit tx_write, tx_bank;
    logic [2:0] tx_addr;
    int tx_wait;
    int su_cnt, st_cnt, ho_cnt;
    bit seen_st, oe_bad, sel_bad, dual_bad, cap_seen, cap_oe;
    logic [15:0] cap_data;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit cs_on = !bus_cs0_n || !bus_cs1_n;
            automatic bit st_on = !bus_rd_n || !bus_wr_n;
            automatic bit exp_oe;
            if (st_on) begin
                seen_st = 1'b1; st_cnt++;
            end else if (cs_on) begin
                if (!seen_st) su_cnt++; else ho_cnt++;
            end
            if (!bus_rd_n && !bus_wr_n) dual_bad = 1'b1;
            if (!bus_cs0_n && !bus_cs1_n) dual_bad = 1'b1;
            if (cs_on && (bus_cs0_n != (tx_bank != 1'b0) || bus_addr != tx_addr)) sel_bad = 1'b1;
            if (st_on && (bus_wr_n == tx_write)) sel_bad = 1'b1;
            exp_oe = tx_write && cs_on && (!seen_st || st_on || ho_cnt == 1);
            if (bus_doe !== exp_oe) oe_bad = 1'b1;
            if (st_on) begin
                automatic bit last = (st_cnt >= W_CYC + tx_wait);
                bus_rdy = last;
                bus_din = last ? mem[tx_bank][tx_addr] : ~mem[tx_bank][tx_addr];
            end else begin
                bus_rdy = 1'b1;
                bus_din = 16'h5AA5;
            end
        end
    end

    always @(posedge bus_wr_n) begin
        if (!rst) begin
            cap_seen = 1'b1; cap_data = bus_dout; cap_oe = bus_doe;
        end
    end

    logic [15:0] last_rd = 16'h0;

    task automatic access(bit w, bit b, logic [2:0] a, logic [15:0] d, int wt, bit poke);
        int n;
        bit ok;
        logic [15:0] exp_rd;
        ok = exp_valid(b, a);
        @(negedge clk);
        tx_write = w; tx_bank = b; tx_addr = a; tx_wait = wt;
        su_cnt = 0; st_cnt = 0; ho_cnt = 0;
        seen_st = 0; oe_bad = 0; sel_bad = 0; dual_bad = 0; cap_seen = 0;
        req_valid = 1'b1; req_write = w; req_bank = b; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_done && n < 400) begin
            if (poke && n == 2) begin
                chk("R11 ready low while busy", req_ready, 0);
                req_valid = 1'b1; req_addr = a ^ 3'd1;
            end
            if (poke && n == 3) req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        if (!ok) begin
            chk("R10 done one cycle after accept", n, 1);
            chk("R10 no bus activity", su_cnt + st_cnt + ho_cnt, 0);
            exp_rd = 16'h0;
        end else begin
            chk("R5 done cycle", n, S_CYC + W_CYC + wt + H_CYC + 1);
            chk("R2 setup cycles", su_cnt, S_CYC);
            chk(wt == 0 ? "R3 strobe width" : "R4 stretched strobe", st_cnt, W_CYC + wt);
            chk("R5 hold cycles", ho_cnt, H_CYC);
            chk("R6 select/address/direction", sel_bad, 0);
            chk("R9 output enable window", oe_bad, 0);
            if (w) begin
                chk("R9 write strobe rose with enable", {cap_seen, cap_oe}, 2'b11);
                chk("R7 write lane data", cap_data, exp_fit(b, a, d));
                mem[b][a] = cap_data;
                exp_rd = last_rd;
            end else begin
                exp_rd = exp_fit(b, a, mem[b][a]);
            end
        end
        chk("R12 no overlap", dual_bad, 0);
        chk(w && ok ? "R8 rdata kept over write" : "R8 read data", rsp_rdata, exp_rd);
        last_rd = exp_rd;
        @(negedge clk);
        chk("R5 done single cycle", rsp_done, 0);
        repeat (3) @(negedge clk);
        chk("R11 no late access", {su_cnt + st_cnt + ho_cnt == (ok ? S_CYC + W_CYC + wt + H_CYC : 0),
                                   bus_cs0_n, bus_cs1_n}, 3'b111);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 8; a++) mem[b][a] = 16'($urandom);
        tx_write = 0; tx_bank = 0; tx_addr = 0; tx_wait = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset selects", {bus_cs0_n, bus_cs1_n}, 2'b11);
        chk("R1 reset strobes", {bus_rd_n, bus_wr_n}, 2'b11);
        chk("R1 reset enable/done/ready", {bus_doe, rsp_done, req_ready}, 3'b001);

        access(1, 0, 3'd0, 16'hBEEF, 0, 0);   // R7 wide write
        access(0, 0, 3'd0, 16'h0,    0, 0);   // R8 wide read
        access(1, 0, 3'd2, 16'h1234, 0, 0);   // R7 narrow write
        access(0, 0, 3'd2, 16'h0,    0, 0);   // R7 narrow read
        access(0, 0, 3'd5, 16'h0,    0, 0);   // R7 upper byte masked
        access(1, 1, 3'd6, 16'hC3A7, 0, 0);   // R6 secondary bank
        access(0, 1, 3'd7, 16'h0,    2, 0);   // R4 wait on secondary
        access(0, 1, 3'd3, 16'h0,    0, 0);   // R10 invalid read
        access(1, 1, 3'd0, 16'hFFFF, 0, 0);   // R10 invalid write
        access(0, 0, 3'd7, 16'h0,    3, 1);   // R4 + R11 poke while busy
        access(1, 0, 3'd1, 16'h00AA, 1, 1);   // R9 write with wait, poke

        for (int i = 0; i < 60; i++) begin
            access(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom),
                   int'($urandom % 4), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule